// File: doc/BRIEF.md
# Banked Indirect Memory Addressing Unit

This block is the data-memory front end of a small 8-bit controller. The CPU presents one byte address with a read or write strobe. The block resolves that address to one of three things: a pointer or control register, the accumulator, or a location in one of two internal RAM banks. It then performs the access. Two addresses have no storage of their own. They act as indirect ports, and each is tied to its own 8-bit pointer register.

The first port (00H) always reaches bank 0 at the location held in the first pointer. The second port (02H) reaches the location held in the second pointer, in the bank chosen by a one-bit bank-select register. Plain direct addressing only reaches bank 0. Bank 1 can only be reached through the second port with the bank select set. An indirect access whose pointer names one of the ports reads as zero, and a write through it is dropped.

Top module: `bim_unit`

## Requirements
- R1: A synchronous active-high reset clears the first pointer (01H), the second pointer (03H), the bank select (04H) and the accumulator (05H) to 00H.
- R2: A direct access to 01H, 03H, 04H or 05H reaches the first pointer, the second pointer, the bank select or the accumulator. A direct access to 06H–FFH reaches bank 0 at that address. Writes take effect at the rising clock edge, and reads are combinational in the same cycle.
- R3: An access to 00H uses the location in the first pointer in bank 0, whatever value the bank select holds.
- R4: An access to 02H uses the location in the second pointer: in bank 0 when bank-select bit 0 is 0, and in bank 1 when it is 1.
- R5: Bank 1 is written only by a write to 02H while the bank select is 1. Direct writes and writes through 00H leave bank 1 unchanged.
- R6: An indirect access (through 00H or 02H) whose pointer holds 00H or 02H reads 00H in either bank. A write through it changes no register and no RAM location.
- R7: The bank select stores only bit 0 of written data, and bits 7:1 read back as 0.
- R8: Read data is 00H in every cycle where the read strobe is low.
- R9: The accumulator value is driven continuously on `acc_out`. It can be written directly at 05H, or indirectly through a bank-0 pointer that holds 05H.
- R10: An indirect access in bank 0 whose pointer holds 01H, 03H, 04H or 05H reaches that register, just as a direct access would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | CPU data-space address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Combinational read data, 00H when idle |
| acc_out | output | 8 | Current accumulator value |

## Verification
A wrong pointer or bank-select value shows up on the same cycle that an indirect read uses it: the read returns the data of a neighbouring location or of the other bank. The bench therefore fills each bank with a distinct address-derived pattern and reads every location back through every path, so one misrouted bit changes a compared byte at once. A write that leaks into the wrong bank or register stays hidden until that location is read. For that reason each write sweep is followed by a full read-back of the other bank and of the registers. A self-reference write that is not blocked shows on the next read of the pointer registers or the accumulator.

// File: rtl/bim_pkg.sv
package bim_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_PORT0 = 8'h00;
    localparam logic [ADDR_W-1:0] A_PTR0  = 8'h01;
    localparam logic [ADDR_W-1:0] A_PORT1 = 8'h02;
    localparam logic [ADDR_W-1:0] A_PTR1  = 8'h03;
    localparam logic [ADDR_W-1:0] A_BANK  = 8'h04;
    localparam logic [ADDR_W-1:0] A_ACC   = 8'h05;

    // Kind of storage an access finally lands on
    typedef enum logic [2:0] {
        T_VOID,
        T_PTR0,
        T_PTR1,
        T_BANK,
        T_ACC,
        T_RAM
    } target_e;

    // Outcome of address translation
    typedef struct packed {
        target_e             tgt;
        logic                bank;
        logic                indirect;
        logic [ADDR_W-1:0]   loc;
    } route_t;

    // Architectural register state
    typedef struct packed {
        logic [ADDR_W-1:0]   mp0;
        logic [ADDR_W-1:0]   mp1;
        logic                bp;
        logic [DATA_W-1:0]   acc;
    } regs_t;

    function automatic logic is_port(input logic [ADDR_W-1:0] a);
        return (a == A_PORT0) || (a == A_PORT1);
    endfunction

    // Bank-0 decode of a non-port location
    function automatic target_e bank0_target(input logic [ADDR_W-1:0] a);
        target_e t;
        case (a)
            A_PTR0:  t = T_PTR0;
            A_PTR1:  t = T_PTR1;
            A_BANK:  t = T_BANK;
            A_ACC:   t = T_ACC;
            default: t = T_RAM;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/bim_xlate.sv
module bim_xlate
    import bim_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mp0,
    input  logic [ADDR_W-1:0] mp1,
    input  logic              bp,
    output route_t            route
);

    always_comb begin
        route          = '0;
        route.tgt      = T_VOID;
        if (addr == A_PORT0) begin
            route.indirect = 1'b1;
            route.bank     = 1'b0;
            route.loc      = mp0;
        end else if (addr == A_PORT1) begin
            route.indirect = 1'b1;
            route.bank     = bp;
            route.loc      = mp1;
        end else begin
            route.indirect = 1'b0;
            route.bank     = 1'b0;
            route.loc      = addr;
        end

        if (route.indirect && is_port(route.loc)) begin
            route.tgt = T_VOID;
        end else if (route.bank) begin
            route.tgt = T_RAM;
        end else begin
            route.tgt = bank0_target(route.loc);
        end
    end

endmodule

// File: rtl/bim_regs.sv
module bim_regs
    import bim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  target_e           tgt,
    input  logic [DATA_W-1:0] wdata,
    output regs_t             regs_q
);

    regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (tgt)
                T_PTR0:  regs_d.mp0 = wdata;
                T_PTR1:  regs_d.mp1 = wdata;
                T_BANK:  regs_d.bp  = wdata[0];
                T_ACC:   regs_d.acc = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/bim_bank.sv
module bim_bank #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              in_range
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign in_range = ({{(32-ADDR_W){1'b0}}, addr} < DEPTH);
    assign idx      = addr[IDX_W-1:0];
    assign rdata    = in_range ? mem[idx] : '0;

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[idx] <= wdata;
        end
    end

endmodule

// File: rtl/bim_unit.sv
module bim_unit
    import bim_pkg::*;
#(
    parameter int unsigned BANK0_DEPTH = 256,
    parameter int unsigned BANK1_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] acc_out
);

    localparam int unsigned NUM_BANKS = 2;

    route_t            route;
    regs_t             regs_q;
    logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
    logic              bank_ok    [NUM_BANKS];
    logic              bank_we    [NUM_BANKS];
    logic [DATA_W-1:0] read_mux;

    bim_xlate u_xlate (
        .addr  (addr),
        .mp0   (regs_q.mp0),
        .mp1   (regs_q.mp1),
        .bp    (regs_q.bp),
        .route (route)
    );

    bim_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en),
        .tgt    (route.tgt),
        .wdata  (wdata),
        .regs_q (regs_q)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int unsigned DEPTH_G = (g == 0) ? BANK0_DEPTH : BANK1_DEPTH;

        assign bank_we[g] = wr_en && (route.tgt == T_RAM) && (route.bank == g[0]);

        bim_bank #(
            .DEPTH  (DEPTH_G),
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk      (clk),
            .we       (bank_we[g]),
            .addr     (route.loc),
            .wdata    (wdata),
            .rdata    (bank_rdata[g]),
            .in_range (bank_ok[g])
        );
    end

    always_comb begin
        case (route.tgt)
            T_PTR0:  read_mux = regs_q.mp0;
            T_PTR1:  read_mux = regs_q.mp1;
            T_BANK:  read_mux = {{(DATA_W-1){1'b0}}, regs_q.bp};
            T_ACC:   read_mux = regs_q.acc;
            T_RAM:   read_mux = route.bank ? bank_rdata[1] : bank_rdata[0];
            default: read_mux = '0;
        endcase
    end

    assign rdata   = rd_en ? read_mux : '0;
    assign acc_out = regs_q.acc;

endmodule

// File: rtl/bim_chk.sv
module bim_chk
    import bim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] acc_out,
    input logic [ADDR_W-1:0] mp0_q,
    input logic [ADDR_W-1:0] mp1_q,
    input logic              bp_q,
    input logic              bank1_we
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mp0_q == '0 && mp1_q == '0 && !bp_q && acc_out == '0));

    p_ptr0_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_PTR0) |=> (mp0_q == $past(wdata)));

    p_direct_no_bank1_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != A_PORT1) |-> !bank1_we);

    p_selfref_read_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_PORT0 && (mp0_q == A_PORT0 || mp0_q == A_PORT1)) |-> (rdata == '0));

    p_selfref_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_PORT0 && (mp0_q == A_PORT0 || mp0_q == A_PORT1))
        |=> ($stable(mp0_q) && $stable(mp1_q) && $stable(bp_q) && $stable(acc_out)));

    p_bank_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_BANK) |-> (rdata[DATA_W-1:1] == '0));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

endmodule

bind bim_unit bim_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wdata    (wdata),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rdata    (rdata),
    .acc_out  (acc_out),
    .mp0_q    (regs_q.mp0),
    .mp1_q    (regs_q.mp1),
    .bp_q     (regs_q.bp),
    .bank1_we (bank_we[1])
);

// File: tb/tb_bim_unit.sv
module tb_bim_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       rd_en;
    logic       wr_en;
    logic [7:0] rdata;
    logic [7:0] acc_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m0 [256];
    logic [7:0] m1 [256];

    always #4 clk = ~clk;

    bim_unit dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .rdata   (rdata),
        .acc_out (acc_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        chk(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h01, 8'h00, "R1 mp0");
        rd(8'h03, 8'h00, "R1 mp1");
        rd(8'h04, 8'h00, "R1 bank");
        rd(8'h05, 8'h00, "R1 acc");
        chk("R1 acc_out", acc_out, 8'h00);

        // R8: idle read is zero
        wr(8'h01, 8'hAA);
        @(negedge clk); addr = 8'h01; rd_en = 1'b0; #1;
        chk("R8 idle", rdata, 8'h00);
        rd(8'h01, 8'hAA, "R2 mp0 direct");

        // R2: direct fill and read-back of bank 0
        for (int a = 6; a < 256; a++) begin
            m0[a] = 8'(a) ^ 8'h5A;
            wr(8'(a), m0[a]);
        end
        for (int a = 6; a < 256; a++) rd(8'(a), m0[a], "R2 bank0 direct");
        wr(8'h03, 8'h66);
        rd(8'h03, 8'h66, "R2 mp1 direct");

        // R7: bank select keeps bit 0 only
        wr(8'h04, 8'hFF);
        rd(8'h04, 8'h01, "R7 bank ff");
        wr(8'h04, 8'hFE);
        rd(8'h04, 8'h00, "R7 bank fe");

        // R4/R5: fill bank 1 through the second port
        wr(8'h04, 8'h01);
        for (int p = 0; p < 256; p++) begin
            if (p != 0 && p != 2) begin
                m1[p] = ~8'(p);
                wr(8'h03, 8'(p));
                wr(8'h02, m1[p]);
            end
        end
        for (int a = 6; a < 256; a++) rd(8'(a), m0[a], "R5 bank0 intact");
        for (int p = 0; p < 256; p++) begin
            if (p != 0 && p != 2) begin
                wr(8'h03, 8'(p));
                rd(8'h02, m1[p], "R4 bank1 via mp1");
            end
        end

        // R3: first port stays in bank 0 with bank select set
        for (int a = 6; a < 256; a++) begin
            wr(8'h01, 8'(a));
            rd(8'h00, m0[a], "R3 mp0 bank0");
        end
        wr(8'h01, 8'h80);
        wr(8'h00, 8'h11);
        m0[8'h80] = 8'h11;
        rd(8'h80, 8'h11, "R3 write via mp0");
        wr(8'h03, 8'h80);
        rd(8'h02, m1[8'h80], "R5 mp0 write kept out of bank1");

        // R5: direct write leaves bank 1 alone
        wr(8'h40, 8'hC7);
        m0[8'h40] = 8'hC7;
        wr(8'h03, 8'h40);
        rd(8'h02, m1[8'h40], "R5 direct write kept out of bank1");

        // R4: second port in bank 0
        wr(8'h04, 8'h00);
        for (int a = 6; a < 256; a++) begin
            wr(8'h03, 8'(a));
            rd(8'h02, m0[a], "R4 mp1 bank0");
        end

        // R6: self reference
        wr(8'h05, 8'h3C);
        wr(8'h03, 8'h77);
        wr(8'h01, 8'h00);
        rd(8'h00, 8'h00, "R6 mp0=00 read");
        wr(8'h00, 8'hE1);
        rd(8'h01, 8'h00, "R6 mp0 kept");
        rd(8'h03, 8'h77, "R6 mp1 kept");
        rd(8'h04, 8'h00, "R6 bank kept");
        rd(8'h05, 8'h3C, "R6 acc kept");
        wr(8'h01, 8'h02);
        rd(8'h00, 8'h00, "R6 mp0=02 read");
        wr(8'h00, 8'hE2);
        rd(8'h01, 8'h02, "R6 mp0 kept 2");
        wr(8'h04, 8'h01);
        wr(8'h03, 8'h00);
        rd(8'h02, 8'h00, "R6 mp1=00 bank1 read");
        wr(8'h02, 8'hE3);
        rd(8'h03, 8'h00, "R6 mp1 kept");
        rd(8'h05, 8'h3C, "R6 acc kept 2");
        wr(8'h03, 8'h02);
        wr(8'h04, 8'h00);
        rd(8'h02, 8'h00, "R6 mp1=02 bank0 read");

        // R10: pointers aimed at registers
        wr(8'h01, 8'h03);
        wr(8'h00, 8'h44);
        rd(8'h03, 8'h44, "R10 mp1 via mp0");
        wr(8'h03, 8'h01);
        wr(8'h02, 8'h04);
        rd(8'h01, 8'h04, "R10 mp0 via mp1");
        wr(8'h04, 8'h01);
        rd(8'h00, 8'h01, "R10 bank via mp0");

        // R9: accumulator
        wr(8'h05, 8'h5C);
        @(negedge clk); #1;
        chk("R9 acc_out direct", acc_out, 8'h5C);
        rd(8'h05, 8'h5C, "R9 acc read");
        wr(8'h01, 8'h05);
        wr(8'h00, 8'hC3);
        @(negedge clk); #1;
        chk("R9 acc_out indirect", acc_out, 8'hC3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule